// File: doc/BRIEF.md
# Sized Shift Unit with Condition Flags

This unit performs the register-shift step of a 32-bit integer datapath in a single pass. It takes the 16-bit shift opcode, the current destination word, a count register value and the incoming extend flag. It returns the destination word with only the low byte, word or long replaced, together with the five condition flags extend, negative, zero, overflow and carry. Left and right shifts are supported, each as logical or arithmetic.

The count comes from either a 3-bit immediate field of the opcode or the low six bits of a register. The flags follow exact-last-bit rules: carry is the final bit pushed out of the operand, extend copies carry except when nothing moved, and overflow has two modes. Legacy mode reports any change of the sign bit during an arithmetic left shift. Simplified mode always clears overflow. By default the unit is purely combinational. A parameter adds one register stage at the outputs.

Top module: `cc_shifter`

## Requirements
- R1: Opcode bit 8 selects the direction (1 = left, 0 = right) and opcode bit 3 selects the kind (1 = logical, 0 = arithmetic). Left shifts and logical right shifts fill with zeros. Arithmetic right shifts fill with copies of the sized sign bit.
- R2: When `is_imm` is 1, the count is opcode bits 11:9, and the value 0 stands for a count of 8.
- R3: When `is_imm` is 0, the count is `cnt_reg` modulo 64. Counts at or above the operand size shift every bit out.
- R4: `size` encodes 00 = byte, 01 = word, 10 or 11 = long. Only the sized low bits of `dst_out` take the result, and the upper bits equal `dst_in`.
- R5: The carry flag (`flags_out[0]`) is the last bit shifted out. It is 0 when the count is 0.
- R6: The extend flag (`flags_out[4]`) equals carry when the count is non-zero. When the count is 0 it equals `x_in`.
- R7: The negative flag (`flags_out[3]`) is the sized MSB of the result. The zero flag (`flags_out[2]`) is 1 exactly when every sized result bit is 0.
- R8: The overflow flag (`flags_out[1]`) is 0 whenever `legacy_mode` is 0, for every logical shift and for every right shift.
- R9: In legacy mode, an arithmetic left shift sets overflow when the sized sign bit takes a different value at any step of the shift. This holds for counts up to 63.
- R10: For byte and word left shifts with a count of 0, carry is 0 even when the sized sign bit of the operand is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low reset for the optional output stage |
| opcode | input | 16 | Shift opcode: bit 8 direction, bit 3 kind, bits 11:9 immediate count |
| dst_in | input | 32 | Current destination word |
| cnt_reg | input | 32 | Count register value; low 6 bits used |
| is_imm | input | 1 | 1 selects the immediate count, 0 selects the register count |
| size | input | 2 | Operand size code |
| legacy_mode | input | 1 | 1 selects the sign-change overflow rule |
| x_in | input | 1 | Current extend flag |
| dst_out | output | 32 | Merged destination word |
| flags_out | output | 5 | {X, N, Z, V, C} |

## Verification
On every cycle, the assertions check that the upper destination bits are preserved, the zero-count rules for carry and extend, that extend tracks carry for non-zero counts, that the zero flag agrees with the sized output, and the cases where overflow must be 0. Some properties can only be shown by comparing the bench's step-by-step shift model over the full count range. These include the shifted data itself, which bit is the last one out, the arithmetic fill, and whether a sign change during the shift sets overflow. The same applies to decoding the immediate count and to large register counts.

// File: rtl/cc_shifter.sv
module cc_shifter #(
  parameter bit REG_OUT = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] opcode,
  input  logic [31:0] dst_in,
  input  logic [31:0] cnt_reg,
  input  logic        is_imm,
  input  logic [1:0]  size,
  input  logic        legacy_mode,
  input  logic        x_in,
  output logic [31:0] dst_out,
  output logic [4:0]  flags_out
);
  localparam int DW = 32;
  localparam int XW = 2 * DW;
  localparam int CW = 6;

  logic          go_left, is_log, sgn, c_bit, v_bit, ovf;
  logic [CW-1:0] cnt, vcnt, nbits;
  logic [DW-1:0] mask, zx, res, merged;
  logic [XW-1:0] sx, ext, lsh, rsh_l, rsh_a, vsh;
  logic [4:0]    flags;

  assign go_left = opcode[8];
  assign is_log  = opcode[3];

  assign cnt = is_imm ? ((opcode[11:9] == 3'd0) ? CW'(8) : {3'b000, opcode[11:9]})
                      : cnt_reg[CW-1:0];

  always_comb begin
    case (size)
      2'b00:   begin nbits = CW'(8);  mask = 32'h0000_00FF; end
      2'b01:   begin nbits = CW'(16); mask = 32'h0000_FFFF; end
      default: begin nbits = CW'(32); mask = 32'hFFFF_FFFF; end
    endcase
  end

  assign zx  = dst_in & mask;
  assign sgn = dst_in[nbits - CW'(1)];
  assign sx  = sgn ? {{DW{1'b1}}, ~mask | zx} : {{DW{1'b0}}, zx};
  assign ext = is_log ? {{DW{1'b0}}, zx} : sx;

  assign lsh   = {{DW{1'b0}}, zx} << cnt;
  assign rsh_l = ext >> cnt;
  assign rsh_a = $signed(ext) >>> cnt;

  always_comb begin
    if (go_left) begin
      res   = lsh[DW-1:0] & mask;
      c_bit = lsh[nbits];
    end else begin
      res   = (is_log ? rsh_l[DW-1:0] : rsh_a[DW-1:0]) & mask;
      c_bit = (cnt == '0) ? 1'b0 : ext[cnt - CW'(1)];
    end
  end

  assign vcnt  = (cnt > CW'(32)) ? CW'(32) : cnt;
  assign vsh   = sx << vcnt;
  assign ovf   = |((sx ^ vsh) & ({XW{1'b1}} << (nbits - CW'(1))));
  assign v_bit = legacy_mode & go_left & ~is_log & ovf;

  assign merged = (dst_in & ~mask) | res;
  assign flags  = {(cnt != '0) ? c_bit : x_in,
                   res[nbits - CW'(1)],
                   (res == '0),
                   v_bit,
                   c_bit};

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          dst_out   <= '0;
          flags_out <= '0;
        end else begin
          dst_out   <= merged;
          flags_out <= flags;
        end
      end
      logic unused_bits;
      assign unused_bits = ^{opcode[15:12], opcode[7:4], opcode[2:0], cnt_reg[31:6]};
    end else begin : g_comb
      assign dst_out   = merged;
      assign flags_out = flags;
      logic unused_bits;
      assign unused_bits = ^{clk, rst_n, opcode[15:12], opcode[7:4], opcode[2:0], cnt_reg[31:6]};
    end
  endgenerate
endmodule

// File: rtl/cc_shifter_chk.sv
module cc_shifter_chk #(
  parameter bit LAT = 1'b0
) (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] opcode,
  input logic [31:0] dst_in,
  input logic [31:0] cnt_reg,
  input logic        is_imm,
  input logic [1:0]  size,
  input logic        legacy_mode,
  input logic        x_in,
  input logic [31:0] dst_out,
  input logic [4:0]  flags_out
);
  logic        cz;
  logic [31:0] lowpart;
  assign cz = !is_imm && (cnt_reg[5:0] == 6'd0);
  assign lowpart = (size == 2'b00) ? {24'd0, dst_out[7:0]} :
                   (size == 2'b01) ? {16'd0, dst_out[15:0]} : dst_out;

  generate
    if (!LAT) begin : g_chk
      assert_keep_upper_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (size == 2'b00) |-> (dst_out[31:8] == dst_in[31:8]));
      assert_keep_upper_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (size == 2'b01) |-> (dst_out[31:16] == dst_in[31:16]));
      assert_zero_count_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cz |-> (flags_out[0] == 1'b0));
      assert_zero_count_extend_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cz |-> (flags_out[4] == x_in));
      assert_extend_follows_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cz |-> (flags_out[4] == flags_out[0]));
      assert_zero_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flags_out[2] == (lowpart == 32'd0));
      assert_no_v_simple_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !legacy_mode |-> (flags_out[1] == 1'b0));
      assert_no_v_logical_or_right_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode[3] || !opcode[8]) |-> (flags_out[1] == 1'b0));
    end
  endgenerate
endmodule

bind cc_shifter cc_shifter_chk #(.LAT(REG_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .opcode(opcode), .dst_in(dst_in), .cnt_reg(cnt_reg),
  .is_imm(is_imm), .size(size), .legacy_mode(legacy_mode), .x_in(x_in),
  .dst_out(dst_out), .flags_out(flags_out));

// File: tb/sim_cc_shifter.sv
`timescale 1ns/1ps
module sim_cc_shifter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] opcode = '0;
  logic [31:0] dst_in = '0;
  logic [31:0] cnt_reg = '0;
  logic        is_imm = 1'b0;
  logic [1:0]  size = 2'b10;
  logic        legacy_mode = 1'b0;
  logic        x_in = 1'b0;
  logic [31:0] dst_out;
  logic [4:0]  flags_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cc_shifter u0 (.clk(clk), .rst_n(rst_n), .opcode(opcode), .dst_in(dst_in),
    .cnt_reg(cnt_reg), .is_imm(is_imm), .size(size), .legacy_mode(legacy_mode),
    .x_in(x_in), .dst_out(dst_out), .flags_out(flags_out));

  // Step-by-step model: returns {dst[31:0], X, N, Z, V, C}
  function automatic logic [36:0] model(input logic [31:0] d, input int bits, input int cnt,
                                        input bit left, input bit logical, input bit legacy,
                                        input bit xin);
    logic [31:0] m, val;
    logic c, v, om, fill;
    m = (bits == 32) ? 32'hFFFF_FFFF : ((32'h1 << bits) - 1);
    val = d & m;
    c = 1'b0; v = 1'b0;
    for (int i = 0; i < cnt; i++) begin
      om = val[bits-1];
      if (left) begin
        c = val[bits-1];
        val = (val << 1) & m;
        if (val[bits-1] != om) v = 1'b1;
      end else begin
        c = val[0];
        fill = logical ? 1'b0 : om;
        val = (val >> 1) | ({31'd0, fill} << (bits-1));
      end
    end
    v = v & left & ~logical & legacy;
    return {(d & ~m) | val, (cnt != 0) ? c : xin, val[bits-1], (val == 32'd0), v, c};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [1:0] sz, input bit left, input bit logical, input bit imm,
                     input int c, input logic [31:0] d, input bit legacy, input bit xin,
                     input string tag);
    logic [36:0] e;
    int bits, eff;
    bits = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
    @(posedge clk);
    #5;
    size = sz; is_imm = imm; legacy_mode = legacy; x_in = xin; dst_in = d;
    opcode = 16'hE000 | (16'(left) << 8) | (16'(logical) << 3) | (16'(c & 7) << 9);
    cnt_reg = imm ? 32'hDEAD_BEEF : 32'(c);
    eff = imm ? (((c & 7) == 0) ? 8 : (c & 7)) : (c & 63);
    e = model(d, bits, eff, left, logical, legacy, xin);
    #5;
    chk({tag, " R1 data"}, dst_out, e[36:5]);
    chk({tag, " R6 X"}, {31'd0, flags_out[4]}, {31'd0, e[4]});
    chk({tag, " R7 N/Z"}, {30'd0, flags_out[3:2]}, {30'd0, e[3:2]});
    chk({tag, " R9 V"}, {31'd0, flags_out[1]}, {31'd0, e[1]});
    chk({tag, " R5 C"}, {31'd0, flags_out[0]}, {31'd0, e[0]});
  endtask

  initial begin
    logic [31:0] pats [7];
    pats = '{32'h0, 32'h1, 32'h8000_8080, 32'h5A3C_C3A5, 32'h7FFF_7F7F, 32'hFFFF_FFFF, 32'h4000_4040};
    repeat (3) @(posedge clk);
    #5;
    chk("reset R4 dst", dst_out, 32'h0);
    chk("reset R7 flags", {27'd0, flags_out}, {27'd0, 5'b00100});
    rst_n = 1'b1;

    // Directed corners
    run(2'b10, 1, 1, 1, 0, 32'h1, 0, 0, "R2 imm zero=8");
    #1 chk("R2 imm zero=8 value", dst_out, 32'h100);
    run(2'b10, 1, 1, 0, 65, 32'h1, 0, 0, "R3 mod64");
    #1 chk("R3 count 65 acts as 1", dst_out, 32'h2);
    run(2'b10, 0, 1, 0, 32, 32'h8000_0000, 0, 0, "R3 all out");
    #1 chk("R3 count 32 carry", {31'd0, flags_out[0]}, 32'd1);
    run(2'b00, 0, 0, 0, 1, 32'hABCD_EF80, 0, 0, "R4 byte asr");
    #1 chk("R4 byte asr merge", dst_out, 32'hABCD_EFC0);
    run(2'b00, 1, 0, 0, 1, 32'h40, 0, 0, "R8 simple");
    #1 chk("R8 simplified V", {31'd0, flags_out[1]}, 32'd0);
    run(2'b00, 1, 0, 0, 1, 32'h40, 1, 0, "R9 legacy");
    #1 chk("R9 legacy V", {31'd0, flags_out[1]}, 32'd1);
    run(2'b00, 1, 0, 0, 0, 32'h80, 1, 1, "R10 byte zero count");
    #1 chk("R10 byte zero-count C", {31'd0, flags_out[0]}, 32'd0);
    run(2'b01, 1, 0, 0, 0, 32'h8000, 1, 0, "R10 word zero count");
    #1 chk("R10 word zero-count C", {31'd0, flags_out[0]}, 32'd0);

    // Sweeps
    for (int s = 0; s < 3; s++)
      for (int op = 0; op < 4; op++)
        for (int lg = 0; lg < 2; lg++)
          for (int p = 0; p < 7; p++) begin
            for (int c = 0; c < 64; c++)
              run(2'(s), op[1], op[0], 0, c, pats[p], lg[0], c[0], "sweep reg");
            for (int c = 0; c < 8; c++)
              run(2'(s), op[1], op[0], 1, c, pats[p], lg[0], ~c[0], "sweep R2 imm");
          end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule